// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block decides when the rest of a system may run. It watches an already-synchronized supply-good flag and drives one reset output. Reset is held from power-on, and again from any supply dip, until the supply has stayed good for a fixed stretch of clock cycles. The stretch is sized to about 200 ms of the system clock.

A watchdog runs alongside the supply monitor. The host proves that it is alive by pulling the chip-select line low. Only a falling edge on that line restarts the watchdog count, so a line stuck high and a line stuck low both end in a timeout. A timeout drives the same reset, and that reset also lasts the full stretch.

A small control register holds two things: a 2-bit timeout select and a lock-enable bit. The register can be written only while reset is released. It is frozen while the write-protect pin is asserted and the lock-enable bit is set. The polarity of the reset output is chosen by a parameter.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, reset is active and `ctrl_q` equals `{1'b0, SEL_INIT}`. After `por_n` rises with `supply_ok` high, reset releases after exactly `STRETCH_CYCLES` rising clock edges.
- R2: A rising edge at which `supply_ok` is sampled low leaves reset active.
- R3: Reset releases only after `supply_ok` has been high for `STRETCH_CYCLES` consecutive edges. If the supply drops during the stretch, the count starts again from zero.
- R4: With the watchdog enabled, reset is asserted once `cs_n` has shown no falling edge for the selected number of cycles. This holds whether `cs_n` is held high or held low.
- R5: A high-to-low change of `cs_n` restarts the watchdog count. It passes through two synchronizer flops and one edge-detect flop, so the restart happens on the third edge after the change.
- R6: The select field `ctrl_q[1:0]` picks the timeout: 00 selects `WD_T0`, 01 selects `WD_T1`, 10 selects `WD_T2`, and 11 disables the watchdog.
- R7: A watchdog reset lasts `STRETCH_CYCLES` edges. The watchdog count then restarts from zero when reset releases.
- R8: Asserting `wr_en` loads `wr_data` into `ctrl_q` (bit 2 is lock-enable, bits 1:0 are the select) on the next edge. The load happens only while reset is inactive. A write made during reset is ignored.
- R9: While `wp_n` is low and `ctrl_q[2]` is 1, writes are ignored. With `wp_n` high, writes are accepted again.
- R10: With `RST_ACTIVE_HIGH` = 0, `rst_out` is low while reset is active. With `RST_ACTIVE_HIGH` = 1, `rst_out` is high while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on flag, active low, asynchronous |
| supply_ok | input | 1 | Synchronized flag, high while the supply is above the trip level |
| cs_n | input | 1 | Chip select, active low; its falling edge kicks the watchdog |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 3 | Control write data: {lock_en, sel[1:0]} |
| ctrl_q | output | 3 | Current control register value |
| rst_out | output | 1 | Reset output, polarity set by `RST_ACTIVE_HIGH` |

## Verification
The hardest case to reach is a kicked watchdog that is then starved with chip-select held low. The timeout must then be counted from the restart that the synchronized falling edge caused, three edges after the pin moved, and not from the release of reset. The bench kicks at a fixed period that is shorter than the timeout and checks that reset stays released. It then stops kicking with the line low and expects reset exactly the timeout plus the three-edge latency after the last fall. It then measures the length of that watchdog reset and the next timeout, which shows that the count was cleared when reset released.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned STRETCH_CYCLES  = 50_000_000,
  parameter int unsigned WD_T0           = 50_000_000,
  parameter int unsigned WD_T1           = 150_000_000,
  parameter int unsigned WD_T2           = 350_000_000,
  parameter bit          RST_ACTIVE_HIGH = 1'b0,
  parameter logic [1:0]  SEL_INIT        = 2'b00
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_ok,
  input  logic       cs_n,
  input  logic       wp_n,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic [2:0] ctrl_q,
  output logic       rst_out
);
  localparam int unsigned WD_MAX = (WD_T0 > WD_T1) ? ((WD_T0 > WD_T2) ? WD_T0 : WD_T2)
                                                   : ((WD_T1 > WD_T2) ? WD_T1 : WD_T2);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam int WW = $clog2(WD_MAX + 1);
  localparam logic [SW-1:0] S_LAST = SW'(STRETCH_CYCLES - 1);

  logic          rst_act;
  logic [SW-1:0] scnt;
  logic [WW-1:0] wcnt, wd_last;
  logic          cs_s1, cs_s2, cs_prev;
  logic          cs_fall, wd_en, wd_fire, lock;

  assign cs_fall = cs_prev & ~cs_s2;
  assign wd_en   = (ctrl_q[1:0] != 2'b11) & ~rst_act;
  assign wd_fire = wd_en & ~cs_fall & (wcnt >= wd_last);
  assign lock    = ~wp_n & ctrl_q[2];
  assign rst_out = RST_ACTIVE_HIGH ? rst_act : ~rst_act;

  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   wd_last = WW'(WD_T0 - 1);
      2'b01:   wd_last = WW'(WD_T1 - 1);
      2'b10:   wd_last = WW'(WD_T2 - 1);
      default: wd_last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cs_s1   <= 1'b1;
      cs_s2   <= 1'b1;
      cs_prev <= 1'b1;
    end else begin
      cs_s1   <= cs_n;
      cs_s2   <= cs_s1;
      cs_prev <= cs_s2;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_act <= 1'b1;
      scnt    <= '0;
    end else if (!supply_ok || wd_fire) begin
      rst_act <= 1'b1;
      scnt    <= '0;
    end else if (rst_act) begin
      if (scnt == S_LAST) begin
        rst_act <= 1'b0;
        scnt    <= '0;
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      wcnt <= '0;
    else if (!wd_en || cs_fall || wd_fire)
      wcnt <= '0;
    else
      wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      ctrl_q <= {1'b0, SEL_INIT};
    else if (wr_en && !rst_act && !lock)
      ctrl_q <= wr_data;
  end
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
  input logic       clk,
  input logic       por_n,
  input logic       supply_ok,
  input logic       wp_n,
  input logic       rst_act,
  input logic       cs_fall,
  input logic       wcnt_zero,
  input logic [2:0] ctrl_q
);
  a_r2_low_supply_resets: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> rst_act);

  a_r3_release_after_good: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_act) |-> (supply_ok && $past(supply_ok)));

  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!por_n)
    cs_fall |=> wcnt_zero);

  a_r6_disabled_no_timeout: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_q[1:0] == 2'b11 && !rst_act && supply_ok) |=> !rst_act);

  a_r7_idle_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_act |=> wcnt_zero);

  a_r8_frozen_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_act |=> $stable(ctrl_q));

  a_r9_locked: assert property (@(posedge clk) disable iff (!por_n)
    (!wp_n && ctrl_q[2]) |=> $stable(ctrl_q));
endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .supply_ok (supply_ok),
  .wp_n      (wp_n),
  .rst_act   (rst_act),
  .cs_fall   (cs_fall),
  .wcnt_zero (wcnt == '0),
  .ctrl_q    (ctrl_q)
);

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int STR = 20;
  localparam int T0 = 10, T1 = 25, T2 = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_ok = 1'b0, cs_n = 1'b1, wp_n = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [2:0] ctrl_q, ctrl_hi;
  logic rst_lo, rst_hi, rst;
  int checks = 0, fails = 0, mism = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.STRETCH_CYCLES(STR), .WD_T0(T0), .WD_T1(T1), .WD_T2(T2),
                   .RST_ACTIVE_HIGH(1'b0)) uut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .cs_n(cs_n), .wp_n(wp_n),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q), .rst_out(rst_lo));

  rst_supervisor #(.STRETCH_CYCLES(STR), .WD_T0(T0), .WD_T1(T1), .WD_T2(T2),
                   .RST_ACTIVE_HIGH(1'b1)) uut_hi (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .cs_n(cs_n), .wp_n(wp_n),
    .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_hi), .rst_out(rst_hi));

  assign rst = ~rst_lo;

  always @(negedge clk) if (rst_hi !== ~rst_lo) mism++;

  // {sel, expected timeout (0 = none within 80 cycles)}
  localparam logic [8:0] VEC [4] = '{ {2'b00, 7'd10}, {2'b01, 7'd25},
                                      {2'b10, 7'd40}, {2'b11, 7'd0} };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count_release(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst && n < 1000);
  endtask

  task automatic count_fire(input int lim, output int n);
    n = 0;
    while (!rst && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_supply(output int n);
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    count_release(n);
  endtask

  task automatic wait_inactive();
    int k = 0;
    while (rst && k < 1000) begin @(negedge clk); k++; end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(rst === 1'b1, "R1 reset at por", rst, 1);
    check(ctrl_q === 3'b000, "R1 ctrl init", ctrl_q, 0);
    check(rst_lo === 1'b0 && rst_hi === 1'b1, "R10 polarity", rst_hi, 1);
    supply_ok = 1'b1;
    repeat (30) @(negedge clk);
    check(rst === 1'b1, "R1 held by por", rst, 1);
    por_n = 1'b1;
    count_release(n);
    check(n == STR, "R1 release after stretch", n, STR);
    check(rst_lo === 1'b1 && rst_hi === 1'b0, "R10 polarity released", rst_hi, 0);

    // R6 / R4 table: cs_n held high
    for (int i = 0; i < 4; i++) begin
      wait_inactive();
      wr({1'b0, VEC[i][8:7]});
      pulse_supply(n);
      check(n == STR, "R3 stretch", n, STR);
      count_fire(80, n);
      if (VEC[i][6:0] == 0)
        check(!rst && n == 80, "R6 disabled", n, 80);
      else
        check(rst && n == int'(VEC[i][6:0]), "R4 R6 timeout high", n, int'(VEC[i][6:0]));
    end

    // R3 restart on supply drop
    wait_inactive();
    wr(3'b011);
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    repeat (12) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    count_release(n);
    check(n == STR, "R3 restart count", n, STR);

    // R2 drop while released
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    check(rst === 1'b1, "R2 drop asserts", rst, 1);
    supply_ok = 1'b1;
    wait_inactive();

    // R5 kicks then hold low
    wr(3'b001);
    for (int k = 0; k < 8; k++) begin
      cs_n = 1'b0; repeat (5) @(negedge clk);
      cs_n = 1'b1; repeat (10) @(negedge clk);
    end
    check(!rst, "R5 kicks keep released", rst, 0);
    cs_n = 1'b0;
    count_fire(60, n);
    check(rst && n == T1 + 3, "R4 R5 timeout low", n, T1 + 3);
    count_release(n);
    check(n == STR, "R7 wd reset length", n, STR);
    count_fire(60, n);
    check(rst && n == T1, "R7 count cleared", n, T1);
    cs_n = 1'b1;
    wait_inactive();

    // R8 / R9
    wr(3'b110);
    check(ctrl_q === 3'b110, "R8 write", ctrl_q, 6);
    wp_n = 1'b0;
    wr(3'b001);
    check(ctrl_q === 3'b110, "R9 locked", ctrl_q, 6);
    wp_n = 1'b1;
    wr(3'b001);
    check(ctrl_q === 3'b001, "R9 unlocked", ctrl_q, 1);
    @(negedge clk); supply_ok = 1'b0;
    wr(3'b010);
    check(ctrl_q === 3'b001, "R8 ignored in reset", ctrl_q, 1);
    supply_ok = 1'b1;
    wait_inactive();

    check(mism == 0, "R10 outputs complementary", mism, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule